// File: doc/BRIEF.md
# Debug Memory Window Decoder

This block sits behind a debug or host access port and turns a 32-bit byte address plus a transfer length into a decoded target. There are three disjoint windows. The first is a large unified region cut into equal segments. The second is an instruction region and the third is a data region. For an accepted request the block reports which window was hit, the segment index (unified window only) and the local byte offset inside the window.

Before reporting, the block checks the transfer against the window limits. A transfer that cannot be honoured is turned into a zero-length transfer and flagged; it does not stop anything.

The block also keeps a one-bit-per-segment record of which unified segments are backed. When an accepted transfer touches a segment that is not yet backed, the block marks that segment and emits a one-cycle allocate pulse, so a neighbouring block can attach storage. Requests arrive through a valid/ready pair. The registered result appears one cycle after the request is accepted and is held until the consumer takes it.

Top module: `memwin_decoder`

## Requirements
- R1: An address whose bits 31:24 are zero selects the unified window (window code 1). The segment index is address bits 23:17 and the offset is bits 16:0.
- R2: Addresses 0x01000000 through 0x0103FFFF select the instruction window (window code 2), with offset equal to address bits 17:0.
- R3: Addresses 0x02000000 through 0x0200FFFF select the data window (window code 3), with offset equal to address bits 15:0.
- R4: An address in none of the three windows raises the range-error flag. It reports window code 0 and a granted length of 0.
- R5: A unified transfer is rejected with the crossing-error flag when its end address (start + length) falls in a different segment. The one exception is an end address that is exactly offset 0 of the following segment.
- R6: An instruction or data transfer is rejected with the bound-error flag when offset + length exceeds the window size: 2^18 bytes for instruction, 2^16 bytes for data.
- R7: A rejected transfer reports a granted length of 0, and at most one error flag is set. An accepted transfer reports a granted length equal to the requested length.
- R8: After reset, unified segments 0, 1, 2 and 127 count as backed, so accepted accesses to them produce no allocate pulse.
- R9: An accepted access to an unbacked segment marks it backed. It also raises the allocate pulse for exactly one cycle, together with the response. Later accesses to that segment raise no pulse, and a rejected transfer never marks a segment.
- R10: The response is valid in the cycle after a request is accepted. While the response is not taken, it holds stable and the request side is not ready. Request-ready is high whenever no response is pending or the pending one is being taken.
- R11: During and right after reset, no response is valid, the allocate pulse is low and request-ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request this cycle |
| reqAddr | input | 32 | Byte address of the transfer |
| reqLen | input | 18 | Transfer length in bytes |
| rspValid | output | 1 | Decoded result present |
| rspReady | input | 1 | Consumer takes the result this cycle |
| rspWindow | output | 2 | 0 none, 1 unified, 2 instruction, 3 data |
| rspSegment | output | 7 | Unified segment index (0 for other windows) |
| rspOffset | output | 18 | Local byte offset inside the window |
| rspLen | output | 18 | Granted length, 0 when rejected |
| rspRangeErr | output | 1 | Address outside every window |
| rspBoundErr | output | 1 | Instruction/data transfer runs past the window end |
| rspCrossErr | output | 1 | Unified transfer crosses a segment |
| allocPulse | output | 1 | One-cycle pulse: a segment has just been marked backed |

## Verification
Segment allocation and segment-crossing rejection are decided in the same decode cycle. A single request can aim at an unbacked segment and also run past its end. The bench sends such a request to segment 9 and expects the crossing flag, a zero granted length and no allocate pulse. It then sends a legal access to the same segment, and the allocate pulse that follows shows the earlier rejection left the segment unmarked. A second overlap is tested with a stalled response: a new request is offered while the old result sits untaken, and the old fields must stay unchanged until the consumer releases them.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_UNI   = 2'd1,
    WIN_INSTR = 2'd2,
    WIN_DATA  = 2'd3
  } winSel_t;

  typedef struct packed {
    logic capture;  // accept a request into the result register
    logic hold;     // result pending and not taken this cycle
  } winStrobe_t;
endpackage

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
  import memwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rspReady,
  output logic       reqReady,
  output logic       rspValid,
  output winStrobe_t strb
);
  logic pendQ;

  assign reqReady     = !pendQ || rspReady;
  assign strb.capture = reqValid && reqReady;
  assign strb.hold    = pendQ && !rspReady;
  assign rspValid     = pendQ;

  always_ff @(posedge clk) begin
    if (!rstN)              pendQ <= 1'b0;
    else if (strb.capture)  pendQ <= 1'b1;
    else if (rspReady)      pendQ <= 1'b0;
  end

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> rspValid);
  assert_pending_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);
endmodule

// File: rtl/memwin_dpath.sv
module memwin_dpath
  import memwin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 18,
  parameter int SEG_CNT    = 128,
  parameter int SEG_OFF_W  = 17,
  parameter int IMEM_OFF_W = 18,
  parameter int DMEM_OFF_W = 16,
  parameter logic [ADDR_W-1:0] IMEM_BASE = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] DMEM_BASE = 32'h0200_0000,
  localparam int SEG_IDX_W = $clog2(SEG_CNT),
  localparam int OFF_W     = (IMEM_OFF_W > SEG_OFF_W)
                             ? ((IMEM_OFF_W > DMEM_OFF_W) ? IMEM_OFF_W : DMEM_OFF_W)
                             : ((SEG_OFF_W > DMEM_OFF_W) ? SEG_OFF_W : DMEM_OFF_W)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  output logic [1:0]           rspWindow,
  output logic [SEG_IDX_W-1:0] rspSegment,
  output logic [OFF_W-1:0]     rspOffset,
  output logic [LEN_W-1:0]     rspLen,
  output logic                 rspRangeErr,
  output logic                 rspBoundErr,
  output logic                 rspCrossErr,
  output logic                 allocPulse
);
  localparam int UNI_W  = SEG_IDX_W + SEG_OFF_W;
  localparam int SUM_W  = ADDR_W + 1;
  localparam int ESEG_W = SUM_W - SEG_OFF_W;
  localparam logic [SUM_W-1:0] IMEM_SIZE = SUM_W'(1) << IMEM_OFF_W;
  localparam logic [SUM_W-1:0] DMEM_SIZE = SUM_W'(1) << DMEM_OFF_W;

  logic                 uniHit, insHit, datHit;
  logic [SEG_IDX_W-1:0] startSeg;
  logic [SUM_W-1:0]     uniEnd, insEnd, datEnd;
  logic [ESEG_W-1:0]    endSeg, startSegW;
  logic                 endOnEdge, crossBad, insOver, datOver;
  logic                 needAlloc;
  logic [SEG_CNT-1:0]   presentQ;
  winSel_t              winD;
  logic [OFF_W-1:0]     offD;
  logic                 anyErr;

  assign uniHit = (reqAddr[ADDR_W-1:UNI_W] == '0);
  assign insHit = (reqAddr[ADDR_W-1:IMEM_OFF_W] == IMEM_BASE[ADDR_W-1:IMEM_OFF_W]);
  assign datHit = (reqAddr[ADDR_W-1:DMEM_OFF_W] == DMEM_BASE[ADDR_W-1:DMEM_OFF_W]);

  // Unified segment crossing check
  assign startSeg  = reqAddr[UNI_W-1:SEG_OFF_W];
  assign uniEnd    = SUM_W'(reqAddr[UNI_W-1:0]) + SUM_W'(reqLen);
  assign endSeg    = uniEnd[SUM_W-1:SEG_OFF_W];
  assign startSegW = ESEG_W'(startSeg);
  assign endOnEdge = (uniEnd[SEG_OFF_W-1:0] == '0);
  assign crossBad  = (endSeg != startSegW) &&
                     !((endSeg == startSegW + ESEG_W'(1)) && endOnEdge);

  // Flat window bound checks
  assign insEnd  = SUM_W'(reqAddr[IMEM_OFF_W-1:0]) + SUM_W'(reqLen);
  assign datEnd  = SUM_W'(reqAddr[DMEM_OFF_W-1:0]) + SUM_W'(reqLen);
  assign insOver = insEnd > IMEM_SIZE;
  assign datOver = datEnd > DMEM_SIZE;

  assign needAlloc = uniHit && !crossBad && !presentQ[startSeg];

  always_comb begin
    winD = WIN_NONE;
    offD = '0;
    if (uniHit) begin
      winD = WIN_UNI;
      offD = OFF_W'(reqAddr[SEG_OFF_W-1:0]);
    end else if (insHit) begin
      winD = WIN_INSTR;
      offD = OFF_W'(reqAddr[IMEM_OFF_W-1:0]);
    end else if (datHit) begin
      winD = WIN_DATA;
      offD = OFF_W'(reqAddr[DMEM_OFF_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspWindow   <= WIN_NONE;
      rspSegment  <= '0;
      rspOffset   <= '0;
      rspLen      <= '0;
      rspRangeErr <= 1'b0;
      rspBoundErr <= 1'b0;
      rspCrossErr <= 1'b0;
      allocPulse  <= 1'b0;
    end else begin
      allocPulse <= strb.capture && needAlloc;
      if (strb.capture) begin
        rspWindow   <= winD;
        rspSegment  <= uniHit ? startSeg : '0;
        rspOffset   <= offD;
        rspRangeErr <= (winD == WIN_NONE);
        rspCrossErr <= uniHit && crossBad;
        rspBoundErr <= (insHit && insOver) || (datHit && datOver);
        rspLen      <= ((winD == WIN_NONE) || (uniHit && crossBad) ||
                        (insHit && insOver) || (datHit && datOver)) ? '0 : reqLen;
      end
    end
  end

  // Backed-segment bitmap, reset pattern picked per bit
  for (genvar g = 0; g < SEG_CNT; g++) begin : gSeg
    localparam logic RST_VAL = (g < 3) || (g == SEG_CNT - 1);
    always_ff @(posedge clk) begin
      if (!rstN)
        presentQ[g] <= RST_VAL;
      else if (strb.capture && needAlloc && (startSeg == SEG_IDX_W'(g)))
        presentQ[g] <= 1'b1;
    end
  end

  assign anyErr = rspRangeErr || rspBoundErr || rspCrossErr;

  assert_range_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspRangeErr |-> (rspWindow == WIN_NONE) && (rspLen == '0));
  assert_single_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspRangeErr, rspBoundErr, rspCrossErr}));
  assert_reject_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> (rspLen == '0));
  assert_alloc_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    allocPulse |-> (rspWindow == WIN_UNI) && !anyErr);
  assert_cross_unified_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspCrossErr |-> (rspWindow == WIN_UNI));
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> $stable(rspOffset) && $stable(rspWindow) && $stable(rspLen));
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 18,
  parameter int SEG_CNT    = 128,
  parameter int SEG_OFF_W  = 17,
  parameter int IMEM_OFF_W = 18,
  parameter int DMEM_OFF_W = 16,
  localparam int SEG_IDX_W = $clog2(SEG_CNT),
  localparam int OFF_W     = IMEM_OFF_W
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  output logic                 rspValid,
  input  logic                 rspReady,
  output logic [1:0]           rspWindow,
  output logic [SEG_IDX_W-1:0] rspSegment,
  output logic [OFF_W-1:0]     rspOffset,
  output logic [LEN_W-1:0]     rspLen,
  output logic                 rspRangeErr,
  output logic                 rspBoundErr,
  output logic                 rspCrossErr,
  output logic                 allocPulse
);
  winStrobe_t strb;

  memwin_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strb     (strb)
  );

  memwin_dpath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .SEG_CNT    (SEG_CNT),
    .SEG_OFF_W  (SEG_OFF_W),
    .IMEM_OFF_W (IMEM_OFF_W),
    .DMEM_OFF_W (DMEM_OFF_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqLen      (reqLen),
    .rspWindow   (rspWindow),
    .rspSegment  (rspSegment),
    .rspOffset   (rspOffset),
    .rspLen      (rspLen),
    .rspRangeErr (rspRangeErr),
    .rspBoundErr (rspBoundErr),
    .rspCrossErr (rspCrossErr),
    .allocPulse  (allocPulse)
  );

  assert_idle_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> reqReady);
endmodule

// File: tb/memwin_decoder_tb.sv
module memwin_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [17:0] reqLen = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [1:0]  rspWindow;
  logic [6:0]  rspSegment;
  logic [17:0] rspOffset;
  logic [17:0] rspLen;
  logic        rspRangeErr, rspBoundErr, rspCrossErr, allocPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  memwin_decoder u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .rspValid(rspValid), .rspReady(rspReady),
    .rspWindow(rspWindow), .rspSegment(rspSegment), .rspOffset(rspOffset),
    .rspLen(rspLen), .rspRangeErr(rspRangeErr), .rspBoundErr(rspBoundErr),
    .rspCrossErr(rspCrossErr), .allocPulse(allocPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive a request at a falling edge, capture at the rising edge, sample 1 ns later.
  task automatic issue(input logic [31:0] a, input logic [17:0] l);
    @(negedge clk);
    reqAddr  = a;
    reqLen   = l;
    reqValid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic [1:0] win, input logic [6:0] seg,
                           input logic [17:0] off, input logic [17:0] len,
                           input logic [2:0] errs, input logic alloc);
    check({tag, " valid"}, 32'(rspValid), 32'd1);
    check({tag, " window"}, 32'(rspWindow), 32'(win));
    check({tag, " segment"}, 32'(rspSegment), 32'(seg));
    check({tag, " offset"}, 32'(rspOffset), 32'(off));
    check({tag, " len"}, 32'(rspLen), 32'(len));
    check({tag, " errs(range,bound,cross)"}, 32'({rspRangeErr, rspBoundErr, rspCrossErr}), 32'(errs));
    check({tag, " alloc"}, 32'(allocPulse), 32'(alloc));
  endtask

  task automatic testReset();
    check("R11 rspValid after reset", 32'(rspValid), 32'd0);
    check("R11 allocPulse after reset", 32'(allocPulse), 32'd0);
    check("R11 reqReady after reset", 32'(reqReady), 32'd1);
  endtask

  task automatic testUnifiedBacked();
    issue(32'h0000_0010, 18'd4);
    expectRsp("R1 seg0", 2'd1, 7'd0, 18'h10, 18'd4, 3'b000, 1'b0);
    issue(32'h00FE_1234, 18'd8);
    expectRsp("R8 seg127", 2'd1, 7'd127, 18'h1234, 18'd8, 3'b000, 1'b0);
    issue(32'h0004_0000, 18'd1);
    expectRsp("R8 seg2", 2'd1, 7'd2, 18'h0, 18'd1, 3'b000, 1'b0);
    idle();
  endtask

  task automatic testAllocate();
    issue(32'h000A_0004, 18'd2);
    expectRsp("R9 seg5 first", 2'd1, 7'd5, 18'h4, 18'd2, 3'b000, 1'b1);
    idle();
    @(posedge clk); #1;
    check("R9 pulse lasts one cycle", 32'(allocPulse), 32'd0);
    check("R10 response taken", 32'(rspValid), 32'd0);
    issue(32'h000A_0100, 18'd2);
    expectRsp("R9 seg5 again", 2'd1, 7'd5, 18'h100, 18'd2, 3'b000, 1'b0);
    idle();
  endtask

  task automatic testCrossing();
    issue(32'h0001_FFFE, 18'd4);
    expectRsp("R5 crossing", 2'd1, 7'd0, 18'h1FFFE, 18'd0, 3'b001, 1'b0);
    issue(32'h0001_FFFC, 18'd4);
    expectRsp("R5 end on boundary", 2'd1, 7'd0, 18'h1FFFC, 18'd4, 3'b000, 1'b0);
    // Absent segment 9 hit by a crossing transfer: rejection wins over allocation.
    issue(32'h0013_FFFF, 18'd2);
    expectRsp("R7 absent+crossing", 2'd1, 7'd9, 18'h1FFFF, 18'd0, 3'b001, 1'b0);
    issue(32'h0012_0000, 18'd2);
    expectRsp("R9 seg9 still absent", 2'd1, 7'd9, 18'h0, 18'd2, 3'b000, 1'b1);
    idle();
  endtask

  task automatic testFlatWindows();
    issue(32'h0103_FFF0, 18'd16);
    expectRsp("R2 instr at end", 2'd2, 7'd0, 18'h3FFF0, 18'd16, 3'b000, 1'b0);
    issue(32'h0103_FFF0, 18'd17);
    expectRsp("R6 instr over", 2'd2, 7'd0, 18'h3FFF0, 18'd0, 3'b010, 1'b0);
    issue(32'h0200_FFFF, 18'd1);
    expectRsp("R3 data last byte", 2'd3, 7'd0, 18'hFFFF, 18'd1, 3'b000, 1'b0);
    issue(32'h0200_FFFF, 18'd2);
    expectRsp("R6 data over", 2'd3, 7'd0, 18'hFFFF, 18'd0, 3'b010, 1'b0);
    idle();
  endtask

  task automatic testOutOfRange();
    issue(32'h0104_0000, 18'd1);
    expectRsp("R4 above instr", 2'd0, 7'd0, 18'h0, 18'd0, 3'b100, 1'b0);
    issue(32'h0201_0000, 18'd1);
    expectRsp("R4 above data", 2'd0, 7'd0, 18'h0, 18'd0, 3'b100, 1'b0);
    issue(32'h8000_0000, 18'd1);
    expectRsp("R4 high address", 2'd0, 7'd0, 18'h0, 18'd0, 3'b100, 1'b0);
    idle();
  endtask

  task automatic testStall();
    @(negedge clk);
    rspReady = 1'b0;
    issue(32'h0200_0040, 18'd4);
    check("R10 stalled valid", 32'(rspValid), 32'd1);
    check("R10 not ready while pending", 32'(reqReady), 32'd0);
    // Offer a second request while the first is pending.
    issue(32'h0100_0080, 18'd4);
    check("R10 held window", 32'(rspWindow), 32'd3);
    check("R10 held offset", 32'(rspOffset), 32'h40);
    @(negedge clk);
    rspReady = 1'b1;
    @(posedge clk); #1;
    expectRsp("R10 second after release", 2'd2, 7'd0, 18'h80, 18'd4, 3'b000, 1'b0);
    idle();
    @(posedge clk); #1;
    check("R10 drained", 32'(rspValid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testUnifiedBacked();
    testAllocate();
    testCrossing();
    testFlatWindows();
    testOutOfRange();
    testStall();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule